// File: doc/BRIEF.md
# PLL Lock Indicator Timer

This block produces the lock status flag of a digital PLL. Each prescaler tick it compares the magnitude of the signed phase-detector error against an unsigned window threshold. It declares lock only after the error has stayed inside that window for a programmed number of consecutive ticks while the loop is in normal tracking mode.

The operating mode is an input. When a locked loop drops into holdover, the flag is kept high for a grace interval of programmed length. It falls only if holdover is still in force when that interval runs out. Once the flag has fallen, it can rise again only after a fresh, complete qualification period in normal mode. Freerun clears the flag at the next clock edge.

All timing comes from one master clock divided by a prescaler, so lock time and grace time are whole tick counts. The tick period, lock time and grace time are parameters. Mode encoding: `00` normal, `01` holdover, `10` and `11` freerun.

Top module: `pll_lock_timer`

## Requirements
- R1: In normal mode (`00`), `lock_o` rises on the clock edge after the tick that completes LOCK_TICKS consecutive in-window ticks, and never before.
- R2: When holdover (`01`) is entered from the locked state, `lock_o` stays high for GRACE_TICKS prescaler ticks.
- R3: If the mode is still holdover at the tick that ends the grace interval, `lock_o` falls on that edge.
- R4: After a grace expiry, `lock_o` stays low until a full LOCK_TICKS of in-window normal-mode ticks have been counted after the return to normal.
- R5: Any freerun mode (`10` or `11`) drives `lock_o` low on the next clock edge and clears the in-window qualification count.
- R6: A tick whose phase error lies outside the window resets the qualification count to zero, so counting restarts from nothing.
- R7: A return to normal mode during the grace interval keeps `lock_o` high and clears the grace timer, so a later holdover gets a full new grace interval.
- R8: While locked in normal mode, `lock_o` stays high whatever the phase error.
- R9: A sample is in-window when the absolute value of the two's-complement `phase_err_i` is less than or equal to the unsigned `win_i`. The boundary is inclusive, and the most negative code has magnitude 2^(ERR_W-1).
- R10: `rst_n` low forces `lock_o` low at once and clears all timers. Release passes through a two-stage synchronizer, so the logic starts on the third clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_err_i | input | ERR_W | Signed phase-detector error |
| win_i | input | ERR_W | Unsigned lock-window threshold |
| mode_i | input | 2 | Mode: 00 normal, 01 holdover, 1x freerun |
| lock_o | output | 1 | Lock status flag |

## Verification
The assertions assume that `mode_i`, `phase_err_i` and `win_i` are synchronous to `clk` and settle before each edge. They also assume the holdover grace logic sees a mode that stays fixed for at least one cycle. The stimulus meets this by changing inputs only on falling edges and holding every vector for at least one full cycle. It moves between modes in orders that exercise grace entry, cancellation, expiry and freerun override. The phase error covers the window boundary from both signs as well as the most negative code.

// File: rtl/lki_pkg.sv
package lki_pkg;

  typedef enum logic [1:0] {
    ST_UNLOCKED = 2'd0,
    ST_LOCKED   = 2'd1,
    ST_GRACE    = 2'd2
  } lki_state_e;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_HOLD   = 2'b01;

  function automatic logic mode_is_normal(input logic [1:0] m);
    return (m == MODE_NORMAL);
  endfunction

  function automatic logic mode_is_hold(input logic [1:0] m);
    return (m == MODE_HOLD);
  endfunction

  function automatic logic mode_is_free(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/lki_rst_sync.sv
module lki_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/lki_tick_gen.sv
module lki_tick_gen #(
  parameter int TICK_DIV = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          tick;

  always_comb begin
    tick  = (cnt_q == CNT_LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = tick;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);  // R1

  generate
    if (TICK_DIV > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);  // R2
    end
  endgenerate

endmodule

// File: rtl/lki_win_qual.sv
module lki_win_qual #(
  parameter int ERR_W      = 16,
  parameter int LOCK_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             normal_i,
  input  logic [ERR_W-1:0] phase_err_i,
  input  logic [ERR_W-1:0] win_i,
  output logic             qual_done_o
);

  localparam int QW = $clog2(LOCK_TICKS + 1);
  localparam logic [QW-1:0] QUAL_LIM = QW'(LOCK_TICKS);

  logic [ERR_W:0]  err_ext;
  logic [ERR_W:0]  err_mag;
  logic            in_win;
  logic [QW-1:0]   qcnt_q;
  logic [QW-1:0]   qcnt_d;
  logic            done;

  // magnitude carried one bit wider so the most negative code fits
  always_comb begin
    err_ext = {phase_err_i[ERR_W-1], phase_err_i};
    err_mag = err_ext[ERR_W] ? (~err_ext + 1'b1) : err_ext;
    in_win  = (err_mag <= {1'b0, win_i});
  end

  always_comb begin
    done   = (qcnt_q == QUAL_LIM);
    qcnt_d = qcnt_q;
    if (!normal_i) begin
      qcnt_d = '0;
    end else if (tick_i) begin
      if (!in_win) begin
        qcnt_d = '0;
      end else if (!done) begin
        qcnt_d = qcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
    end else begin
      qcnt_q <= qcnt_d;
    end
  end

  assign qual_done_o = done;

  AST_QUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt_q <= QUAL_LIM);  // R1

  AST_QUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt_q != $past(qcnt_q) && qcnt_q != '0) |-> $past(tick_i));  // R1

  AST_OUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (normal_i && tick_i && !in_win) |=> (qcnt_q == '0));  // R6

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_i |=> (qcnt_q == '0));  // R5

endmodule

// File: rtl/lki_lock_fsm.sv
module lki_lock_fsm
  import lki_pkg::*;
#(
  parameter int GRACE_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       qual_done_i,
  output logic       lock_o
);

  localparam int GW = (GRACE_TICKS > 1) ? $clog2(GRACE_TICKS) : 1;
  localparam logic [GW-1:0] GRACE_LAST = GW'(GRACE_TICKS - 1);

  lki_state_e    state_q;
  lki_state_e    state_d;
  logic [GW-1:0] gcnt_q;
  logic [GW-1:0] gcnt_d;
  logic          m_norm;
  logic          m_hold;
  logic          m_free;

  always_comb begin
    m_norm = mode_is_normal(mode_i);
    m_hold = mode_is_hold(mode_i);
    m_free = mode_is_free(mode_i);
  end

  always_comb begin
    state_d = state_q;
    gcnt_d  = gcnt_q;
    unique case (state_q)
      ST_UNLOCKED: begin
        gcnt_d = '0;
        if (m_norm && qual_done_i) begin
          state_d = ST_LOCKED;
        end
      end
      ST_LOCKED: begin
        gcnt_d = '0;
        if (m_free) begin
          state_d = ST_UNLOCKED;
        end else if (m_hold) begin
          state_d = ST_GRACE;
        end
      end
      ST_GRACE: begin
        if (m_free) begin
          state_d = ST_UNLOCKED;
          gcnt_d  = '0;
        end else if (m_norm) begin
          state_d = ST_LOCKED;
          gcnt_d  = '0;
        end else if (tick_i) begin
          if (gcnt_q == GRACE_LAST) begin
            state_d = ST_UNLOCKED;
            gcnt_d  = '0;
          end else begin
            gcnt_d = gcnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_UNLOCKED;
        gcnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNLOCKED;
      gcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      gcnt_q  <= gcnt_d;
    end
  end

  assign lock_o = (state_q != ST_UNLOCKED);

  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(qual_done_i));  // R1

  AST_GRACE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && m_hold && !(tick_i && gcnt_q == GRACE_LAST)) |=> lock_o);  // R2

  AST_GRACE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt_q <= GRACE_LAST);  // R3

  AST_HOLD_NO_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && m_hold) |=> !lock_o);  // R4

  AST_FREE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    m_free |=> !lock_o);  // R5

  AST_GRACE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRACE && m_norm) |=> (lock_o && gcnt_q == '0));  // R7

  AST_NORMAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && m_norm) |=> lock_o);  // R8

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer
  import lki_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int TICK_DIV    = 20000,
  parameter int LOCK_TICKS  = 1000,
  parameter int GRACE_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] phase_err_i,
  input  logic [ERR_W-1:0] win_i,
  input  logic [1:0]       mode_i,
  output logic             lock_o
);

  logic rst_n_int;
  logic tick;
  logic normal;
  logic qual_done;

  assign normal = mode_is_normal(mode_i);

  lki_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  lki_tick_gen #(
    .TICK_DIV (TICK_DIV)
  ) u_tick_gen (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_o (tick)
  );

  lki_win_qual #(
    .ERR_W      (ERR_W),
    .LOCK_TICKS (LOCK_TICKS)
  ) u_win_qual (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .tick_i      (tick),
    .normal_i    (normal),
    .phase_err_i (phase_err_i),
    .win_i       (win_i),
    .qual_done_o (qual_done)
  );

  lki_lock_fsm #(
    .GRACE_TICKS (GRACE_TICKS)
  ) u_lock_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .tick_i      (tick),
    .mode_i      (mode_i),
    .qual_done_i (qual_done),
    .lock_o      (lock_o)
  );

  AST_RESET_UNLOCKED: assert property (@(posedge clk)
    !rst_n |=> !lock_o);  // R10

endmodule

// File: tb/pll_lock_timer_bench.sv
module pll_lock_timer_bench;

  localparam int ERR_W = 12;
  localparam int NV    = 22;

  logic             clk;
  logic             rst_n;
  logic [ERR_W-1:0] phase_err;
  logic [ERR_W-1:0] win;
  logic [1:0]       mode;
  logic             lock;

  int n_checks;
  int n_fails;
  bit finished;

  // fields: mode(2) err(12) win(12) cycles(8) expected lock(1) requirement(4)
  localparam logic [38:0] VEC [NV] = '{
    {2'b00, 12'(3),     12'd10,   8'd16, 1'b0, 4'd1},   // R1 not yet qualified
    {2'b00, 12'(3),     12'd10,   8'd8,  1'b1, 4'd1},   // R1 locks after 5 ticks
    {2'b01, 12'(3),     12'd10,   8'd4,  1'b1, 4'd2},   // R2 grace starts
    {2'b01, 12'(3),     12'd10,   8'd6,  1'b1, 4'd2},   // R2 still in grace
    {2'b01, 12'(3),     12'd10,   8'd4,  1'b0, 4'd3},   // R3 grace expired
    {2'b00, 12'(-4),    12'd10,   8'd16, 1'b0, 4'd4},   // R4 partial relock
    {2'b00, 12'(-4),    12'd10,   8'd4,  1'b1, 4'd4},   // R4 full relock
    {2'b00, 12'(-50),   12'd10,   8'd4,  1'b1, 4'd8},   // R8 error ignored
    {2'b01, 12'(0),     12'd10,   8'd4,  1'b1, 4'd2},   // R2 second grace
    {2'b00, 12'(0),     12'd10,   8'd4,  1'b1, 4'd7},   // R7 grace cancelled
    {2'b01, 12'(0),     12'd10,   8'd8,  1'b1, 4'd7},   // R7 full new grace
    {2'b10, 12'(0),     12'd10,   8'd1,  1'b0, 4'd5},   // R5 freerun
    {2'b00, 12'(-10),   12'd10,   8'd20, 1'b1, 4'd9},   // R9 inclusive bound
    {2'b11, 12'(0),     12'd10,   8'd1,  1'b0, 4'd5},   // R5 code 11
    {2'b00, 12'(2),     12'd10,   8'd12, 1'b0, 4'd6},   // R6 three ticks in
    {2'b00, 12'(11),    12'd10,   8'd4,  1'b0, 4'd6},   // R6 out of window
    {2'b00, 12'(-2),    12'd10,   8'd16, 1'b0, 4'd6},   // R6 restarted count
    {2'b00, 12'(-2),    12'd10,   8'd6,  1'b1, 4'd6},   // R6 lock after restart
    {2'b10, 12'(0),     12'd10,   8'd1,  1'b0, 4'd5},   // R5 freerun again
    {2'b00, 12'(-2048), 12'd4095, 8'd22, 1'b1, 4'd9},   // R9 most negative
    {2'b10, 12'(0),     12'd10,   8'd1,  1'b0, 4'd5},   // R5
    {2'b00, 12'(-11),   12'd10,   8'd28, 1'b0, 4'd9}    // R9 just outside
  };

  pll_lock_timer #(
    .ERR_W       (ERR_W),
    .TICK_DIV    (4),
    .LOCK_TICKS  (5),
    .GRACE_TICKS (3)
  ) u_pll_lock_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_err_i (phase_err),
    .win_i       (win),
    .mode_i      (mode),
    .lock_o      (lock)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic exp, input int req, input string what);
    n_checks++;
    if (lock !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: lock_o=%b expected %b", req, what, lock, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fails++;
      $display("FAIL R10 watchdog: run hung, lock_o=%b expected completion", lock);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    finished  = 0;
    rst_n     = 1'b0;
    mode      = 2'b00;
    phase_err = '0;
    win       = 12'd10;
    repeat (3) @(negedge clk);
    check(1'b0, 10, "reset state");  // R10
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, 10, "after sync release");  // R10

    for (int i = 0; i < NV; i++) begin
      mode      = VEC[i][38:37];
      phase_err = VEC[i][36:25];
      win       = VEC[i][24:13];
      repeat (int'(VEC[i][12:5])) @(negedge clk);
      check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // directed: lock, then asynchronous reset takes effect at once (R10)
    mode      = 2'b00;
    phase_err = 12'(1);
    win       = 12'd10;
    repeat (30) @(negedge clk);
    check(1'b1, 1, "relock before reset");  // R1
    rst_n = 1'b0;
    #1;
    check(1'b0, 10, "async reset clears lock");  // R10
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(1'b0, 10, "timers restart after reset");  // R10
    repeat (4) @(negedge clk);
    check(1'b1, 1, "lock after reset qualification");  // R1

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule